// File: doc/BRIEF.md
# DRAM refresh and power-up sequencer

This block generates every cycle an asynchronous page-mode DRAM needs that does not carry data. Out of reset it stays silent for a programmable power-up pause. It then borrows the shared DRAM bus and issues a train of row-strobe-only wake-up pulses, and after that it raises `ready` so the access controller may begin normal traffic. From then on a free-running interval timer marks a refresh as due at an even spacing, so that the device's 512 rows are revisited within its retention period. Each due refresh is a column-strobe-first cycle: the device keeps its own row counter, so the block never drives an address.

Bus ownership uses a request/grant pair. While the grant is withheld, due refreshes pile up in a saturating backlog counter, and the backlog is drained as a back-to-back burst in a single grant. A sleep request moves the device into self refresh. The entry cycle holds both strobes low for at least the self-refresh minimum and until a wake request arrives. Exit parks both strobes high for the self-refresh precharge time and then runs one column-first refresh at once before the bus is returned.

Top module: `dram_refresh_seq`

## Requirements
- R1: During reset and in the cycle after it, `ras_n`, `cas_lo_n` and `cas_hi_n` are 1 and `bus_req`, `ready` and `in_self` are 0.
- R2: After reset is released, `bus_req` first rises PAUSE_CYC clock cycles later.
- R3: Once granted after the pause, the block issues exactly INIT_CYC row-strobe pulses with both column strobes held high, and then raises `ready`.
- R4: After `ready` is set, every fall of `ras_n` is preceded by exactly CSR_CYC cycles with the column strobe low and `ras_n` high.
- R5: Every RAS pulse outside self refresh lasts exactly RAS_CYC cycles, and `ras_n` stays high for at least RP_CYC cycles before `bus_req` falls.
- R6: With the grant always available, successive refresh requests rise REF_INTERVAL cycles apart.
- R7: Refreshes that fall due while the grant is withheld are counted up to MAX_PEND, and the whole count is issued as one burst inside the next grant.
- R8: The strobes go low only while `bus_gnt` is high, and a raised `bus_req` is held until it is granted.
- R9: With BOTH_CAS = 1, `cas_hi_n` always equals `cas_lo_n`. With BOTH_CAS = 0, `cas_hi_n` stays at 1.
- R10: `sleep_req` sampled while the block is idle starts a self-refresh entry in which RAS stays low for at least SELF_MIN_CYC cycles and until `wake_req` is seen. `in_self` is 1 for exactly that low period.
- R11: On wake, both strobes stay high for SELF_RP_CYC cycles, then plus the CSR_CYC setup, then exactly one column-first refresh runs, and then `bus_req` drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_gnt | input | 1 | Grant of the DRAM bus from the access controller |
| sleep_req | input | 1 | Request to place the DRAM in self refresh |
| wake_req | input | 1 | Request to leave self refresh |
| bus_req | output | 1 | Request for the DRAM bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower-byte column strobe, active low |
| cas_hi_n | output | 1 | Upper-byte column strobe, active low |
| ready | output | 1 | Power-up initialization is complete |
| in_self | output | 1 | The DRAM is held in self refresh |

## Verification
The properties assume that `bus_gnt` is high only while `bus_req` is high, and that once given it stays high until the request drops. Without this, a burst or a self-refresh hold could be cut off in the middle. The bench meets that assumption by forming the grant combinationally as the request gated by an enable, and it lowers the enable only after the request has fallen. `sleep_req` and `wake_req` are changed only between clock edges and are held until the block answers on `in_self`, so the entry and exit are always observed in full.

// File: rtl/dram_refresh_pkg.sv
// Shared types for the DRAM refresh sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package dram_refresh_pkg;

    // Sequencer phases; strobe levels are decoded from these.
    typedef enum logic [2:0] {
        ST_PAUSE,   // power-up wait, bus not requested
        ST_WAIT,    // bus requested, waiting for grant
        ST_SETUP,   // column strobe low ahead of the row strobe
        ST_STROBE,  // row strobe low for the pulse width
        ST_PRECH,   // both strobes high for precharge
        ST_IDLE,    // bus released, timer running
        ST_SLEEP,   // both strobes low, device self-refreshing
        ST_WAKE     // both strobes high after self refresh
    } seq_state_e;

    // Kind of cycle the sequencer is currently running.
    typedef enum logic [1:0] {
        OP_INIT,    // row-strobe-only wake-up pulse
        OP_REFRESH, // periodic column-first refresh
        OP_ENTER,   // self-refresh entry
        OP_EXIT     // mandatory refresh after self refresh
    } seq_op_e;

endpackage

// File: rtl/rfsh_interval.sv
// Refresh interval timer: pulses tick once every INTERVAL cycles while run is high.
// Assumes: INTERVAL >= 2. Dropping run reloads the count so spacing restarts cleanly.
module rfsh_interval #(
    parameter int INTERVAL = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL);

    logic [CW-1:0] cnt;

    // Tick is due in the cycle the count reaches zero.
    assign tick = run && (cnt == '0);

    // Count down while running, reload on expiry or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || cnt == '0) begin
            cnt <= CW'(INTERVAL - 1);
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_backlog.sv
// Saturating count of refreshes that are due but not yet issued.
// Assumes: inc and dec may coincide; clear wins over both.
module rfsh_backlog #(
    parameter int MAX_PEND = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    input  logic dec,
    output logic has_work
);
    localparam int BW = $clog2(MAX_PEND + 1);

    logic [BW-1:0] pend;

    assign has_work = (pend != '0);

    // Add due refreshes up to the limit, remove issued ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pend <= '0;
        end else if (inc && !dec) begin
            if (pend != BW'(MAX_PEND)) pend <= pend + 1'b1;
        end else if (dec && !inc) begin
            if (pend != '0) pend <= pend - 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_pins.sv
// Strobe output stage: turns active-high strobe enables into active-low pins.
// Assumes: BOTH_CAS selects driving the upper column strobe along with the lower one,
// since one column strobe is enough to start a column-first refresh.
module rfsh_pins #(
    parameter bit BOTH_CAS = 1'b1
) (
    input  logic ras_on,
    input  logic cas_on,
    output logic ras_n,
    output logic cas_lo_n,
    output logic cas_hi_n
);
    assign ras_n    = !ras_on;
    assign cas_lo_n = !cas_on;

    generate
        if (BOTH_CAS) begin : g_pair
            assign cas_hi_n = !cas_on;
        end else begin : g_single
            assign cas_hi_n = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/dram_refresh_seq.sv
// DRAM refresh and power-up sequencer top.
// Runs the power-up pause, the wake-up row pulses, periodic column-first refreshes with a
// backlog burst, and self-refresh entry/exit. All times are in clock cycles.
// Assumes: bus_gnt is only high while bus_req is high and stays high until bus_req drops.
module dram_refresh_seq #(
    parameter int PAUSE_CYC    = 40000, // power-up pause
    parameter int INIT_CYC     = 8,     // wake-up row pulses
    parameter int REF_INTERVAL = 3120,  // spacing of periodic refreshes
    parameter int RAS_CYC      = 10,    // row strobe low width
    parameter int RP_CYC       = 6,     // row precharge width
    parameter int CSR_CYC      = 2,     // column-before-row setup
    parameter int MAX_PEND     = 4,     // backlog limit
    parameter int SELF_MIN_CYC = 20000, // minimum self-refresh hold
    parameter int SELF_RP_CYC  = 20,    // precharge on self-refresh exit
    parameter bit BOTH_CAS     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_gnt,
    input  logic sleep_req,
    input  logic wake_req,
    output logic bus_req,
    output logic ras_n,
    output logic cas_lo_n,
    output logic cas_hi_n,
    output logic ready,
    output logic in_self
);
    import dram_refresh_pkg::*;

    localparam int TW = $clog2(PAUSE_CYC + SELF_MIN_CYC + RAS_CYC + RP_CYC
                               + CSR_CYC + SELF_RP_CYC + 1);
    localparam int IW = $clog2(INIT_CYC) + 1;

    seq_state_e     state;
    seq_op_e        op;
    logic [TW-1:0]  tmr;
    logic [IW-1:0]  init_left;
    logic           self_seq;
    logic           tick;
    logic           has_work;
    logic           done_one;
    logic           ras_on;
    logic           cas_on;

    // A periodic refresh is retired as its row pulse ends.
    assign done_one = (state == ST_STROBE) && (tmr == '0) && (op == OP_REFRESH);

    // Strobe and request decode from the phase.
    assign ras_on  = (state == ST_STROBE) || (state == ST_SLEEP);
    assign cas_on  = (state == ST_SETUP) || (state == ST_SLEEP)
                   || ((state == ST_STROBE) && (op != OP_INIT));
    assign bus_req = (state != ST_PAUSE) && (state != ST_IDLE);
    assign in_self = (state == ST_SLEEP);

    rfsh_interval #(.INTERVAL(REF_INTERVAL)) u_interval (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ready && !self_seq),
        .tick  (tick)
    );

    rfsh_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!ready || self_seq),
        .inc      (tick),
        .dec      (done_one),
        .has_work (has_work)
    );

    rfsh_pins #(.BOTH_CAS(BOTH_CAS)) u_pins (
        .ras_on   (ras_on),
        .cas_on   (cas_on),
        .ras_n    (ras_n),
        .cas_lo_n (cas_lo_n),
        .cas_hi_n (cas_hi_n)
    );

    // Sequencer: phase transitions, the shared phase timer and the wake-up pulse count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_PAUSE;
            op        <= OP_INIT;
            tmr       <= TW'(PAUSE_CYC - 1);
            init_left <= IW'(INIT_CYC - 1);
            ready     <= 1'b0;
            self_seq  <= 1'b0;
        end else begin
            case (state)
                ST_PAUSE: begin
                    if (tmr == '0) state <= ST_WAIT;
                    else           tmr   <= tmr - 1'b1;
                end
                ST_WAIT: begin
                    if (bus_gnt) begin
                        if (op == OP_INIT) begin
                            state <= ST_STROBE;
                            tmr   <= TW'(RAS_CYC - 1);
                        end else begin
                            state <= ST_SETUP;
                            tmr   <= TW'(CSR_CYC - 1);
                        end
                    end
                end
                ST_SETUP: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else if (op == OP_ENTER) begin
                        state <= ST_SLEEP;
                        tmr   <= TW'(SELF_MIN_CYC - 1);
                    end else begin
                        state <= ST_STROBE;
                        tmr   <= TW'(RAS_CYC - 1);
                    end
                end
                ST_STROBE: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else begin
                        state <= ST_PRECH;
                        tmr   <= TW'(RP_CYC - 1);
                    end
                end
                ST_PRECH: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else begin
                        case (op)
                            OP_INIT: begin
                                if (init_left != '0) begin
                                    init_left <= init_left - 1'b1;
                                    state     <= ST_STROBE;
                                    tmr       <= TW'(RAS_CYC - 1);
                                end else begin
                                    state <= ST_IDLE;
                                    ready <= 1'b1;
                                end
                            end
                            OP_REFRESH: begin
                                if (has_work) begin
                                    state <= ST_SETUP;
                                    tmr   <= TW'(CSR_CYC - 1);
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            default: begin
                                state    <= ST_IDLE;
                                self_seq <= 1'b0;
                            end
                        endcase
                    end
                end
                ST_IDLE: begin
                    if (sleep_req) begin
                        op       <= OP_ENTER;
                        self_seq <= 1'b1;
                        state    <= ST_WAIT;
                    end else if (has_work) begin
                        op    <= OP_REFRESH;
                        state <= ST_WAIT;
                    end
                end
                ST_SLEEP: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else if (wake_req) begin
                        state <= ST_WAKE;
                        tmr   <= TW'(SELF_RP_CYC - 1);
                    end
                end
                ST_WAKE: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else begin
                        state <= ST_SETUP;
                        op    <= OP_EXIT;
                        tmr   <= TW'(CSR_CYC - 1);
                    end
                end
                default: state <= ST_PAUSE;
            endcase
        end
    end
endmodule

// File: rtl/dram_refresh_chk.sv
// Property checker for dram_refresh_seq, attached by bind.
// Assumes: bus_gnt is only given while bus_req is high and held until it drops.
module dram_refresh_chk #(
    parameter int RAS_CYC      = 10,
    parameter int SELF_MIN_CYC = 20000
) (
    input logic clk,
    input logic rst_n,
    input logic bus_gnt,
    input logic wake_req,
    input logic bus_req,
    input logic ras_n,
    input logic cas_lo_n,
    input logic ready,
    input logic in_self
);
    int   low_cnt;
    logic self_seen;

    // Length of the current row-strobe low period and whether it was a self-refresh hold.
    always_ff @(posedge clk) begin
        if (!rst_n || ras_n) begin
            low_cnt   <= 0;
            self_seen <= 1'b0;
        end else begin
            low_cnt   <= low_cnt + 1;
            self_seen <= self_seen || in_self;
        end
    end

    p_init_ras_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !ready) |-> cas_lo_n);

    p_cas_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && ready) |-> ($past(!cas_lo_n) && !cas_lo_n));

    p_ras_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n) && !self_seen) |-> (low_cnt == RAS_CYC));

    p_strobe_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_lo_n) |-> bus_gnt);

    p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    p_self_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n) && self_seen) |-> (low_cnt >= SELF_MIN_CYC));

    p_self_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_self && !wake_req) |=> in_self);
endmodule

bind dram_refresh_seq dram_refresh_chk #(
    .RAS_CYC      (RAS_CYC),
    .SELF_MIN_CYC (SELF_MIN_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_gnt  (bus_gnt),
    .wake_req (wake_req),
    .bus_req  (bus_req),
    .ras_n    (ras_n),
    .cas_lo_n (cas_lo_n),
    .ready    (ready),
    .in_self  (in_self)
);

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps
// Self-checking bench for dram_refresh_seq with shortened timing parameters.
module dram_refresh_seq_tb;
    localparam int PAUSE = 50;
    localparam int INIT  = 8;
    localparam int INTV  = 100;
    localparam int RASW  = 4;
    localparam int RPW   = 3;
    localparam int CSRW  = 2;
    localparam int MAXP  = 3;
    localparam int SMIN  = 40;
    localparam int SRP   = 5;

    // Grant withheld for {N} intervals, expected burst length = min(N, MAXP).
    localparam int VEC [5][2] = '{'{1, 1}, '{2, 2}, '{3, 3}, '{5, 3}, '{2, 2}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic allow = 1'b1;
    logic sleep_req = 1'b0;
    logic wake_req = 1'b0;
    logic bus_gnt;
    logic bus_req, ras_n, cas_lo_n, cas_hi_n, ready, in_self;

    int n_chk = 0;
    int n_fail = 0;
    int ras_falls = 0;
    int init_pulses = 0;
    int last_gap = 0;
    int last_self = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign bus_gnt = bus_req && allow;

    dram_refresh_seq #(
        .PAUSE_CYC(PAUSE), .INIT_CYC(INIT), .REF_INTERVAL(INTV), .RAS_CYC(RASW),
        .RP_CYC(RPW), .CSR_CYC(CSRW), .MAX_PEND(MAXP), .SELF_MIN_CYC(SMIN),
        .SELF_RP_CYC(SRP), .BOTH_CAS(1'b1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .sleep_req(sleep_req),
        .wake_req(wake_req), .bus_req(bus_req), .ras_n(ras_n), .cas_lo_n(cas_lo_n),
        .cas_hi_n(cas_hi_n), .ready(ready), .in_self(in_self)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic rise_gap(output int g);
        g = 0;
        while (bus_req) begin step(); g++; end
        while (!bus_req) begin step(); g++; end
    endtask

    // Pin monitor: pulse widths, setup runs and precharge, sampled mid-cycle.
    bit prev_ras = 1'b1;
    bit prev_req = 1'b0;
    bit self_pulse = 1'b0;
    int low_run = 0;
    int high_run = 0;
    int cas_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !ras_n) begin
                ras_falls++;
                last_gap = high_run;
                chk(cas_hi_n == cas_lo_n, "R9 cas pair", int'(cas_hi_n), int'(cas_lo_n));
                chk(bus_gnt, "R8 strobe under grant", int'(bus_gnt), 1);
                if (!ready) begin
                    init_pulses++;
                    chk(cas_lo_n, "R3 row-only pulse", int'(cas_lo_n), 1);
                end else begin
                    chk(!cas_lo_n && cas_run == CSRW, "R4 column setup", cas_run, CSRW);
                end
            end
            if (!prev_ras && ras_n) begin
                if (self_pulse) begin
                    last_self = low_run;
                    chk(low_run >= SMIN, "R10 self hold", low_run, SMIN);
                end else begin
                    chk(low_run == RASW, "R5 pulse width", low_run, RASW);
                end
            end
            if (prev_req && !bus_req) chk(high_run >= RPW, "R5 precharge", high_run, RPW);
            low_run    = ras_n ? 0 : low_run + 1;
            high_run   = ras_n ? high_run + 1 : 0;
            cas_run    = cas_lo_n ? 0 : cas_run + 1;
            self_pulse = ras_n ? 1'b0 : (self_pulse || in_self);
            prev_ras   = ras_n;
            prev_req   = bus_req;
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 60000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int g;
        int cyc;
        int f0;
        repeat (4) step();
        // R1: quiet outputs during reset
        chk(ras_n && cas_lo_n && cas_hi_n, "R1 strobes", int'(ras_n), 1);
        chk(!bus_req && !ready && !in_self, "R1 req/ready/self", int'(bus_req), 0);
        rst_n = 1'b1;
        chk(ras_n && !bus_req && !ready, "R1 after release", int'(bus_req), 0);
        // R2: pause length
        cyc = 0;
        while (!bus_req) begin step(); cyc++; end
        chk(cyc == PAUSE, "R2 pause", cyc, PAUSE);
        // R3: wake-up pulses then ready
        while (!ready) step();
        chk(init_pulses == INIT, "R3 pulse count", init_pulses, INIT);
        // R6: request spacing with grant free
        rise_gap(g);
        rise_gap(g);
        chk(g == INTV, "R6 spacing", g, INTV);
        rise_gap(g);
        chk(g == INTV, "R6 spacing", g, INTV);
        while (bus_req) step();
        allow = 1'b0;
        // R7: backlog bursts from the vector table
        for (int i = 0; i < 5; i++) begin
            while (!bus_req) step();
            repeat ((VEC[i][0] - 1) * INTV + INTV / 2) step();
            f0 = ras_falls;
            allow = 1'b1;
            while (bus_req) step();
            allow = 1'b0;
            chk(ras_falls - f0 == VEC[i][1], "R7 burst", ras_falls - f0, VEC[i][1]);
        end
        // R10/R11: self refresh with delayed wake
        allow = 1'b1;
        while (bus_req) step();
        sleep_req = 1'b1;
        while (!in_self) step();
        sleep_req = 1'b0;
        repeat (2 * SMIN) step();
        chk(in_self && !ras_n && !cas_lo_n, "R10 held without wake", int'(in_self), 1);
        f0 = ras_falls;
        wake_req = 1'b1;
        while (in_self) step();
        wake_req = 1'b0;
        while (ras_falls == f0) step();
        chk(last_gap == SRP + CSRW, "R11 exit precharge", last_gap, SRP + CSRW);
        while (bus_req) step();
        chk(ras_falls - f0 == 1, "R11 single refresh", ras_falls - f0, 1);
        chk(last_self >= 2 * SMIN, "R10 hold until wake", last_self, 2 * SMIN);
        // R10: immediate wake gives the minimum hold exactly
        sleep_req = 1'b1;
        wake_req = 1'b1;
        while (!in_self) step();
        sleep_req = 1'b0;
        while (in_self) step();
        wake_req = 1'b0;
        while (bus_req) step();
        chk(last_self == SMIN, "R10 minimum hold", last_self, SMIN);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule